// File: doc/BRIEF.md
# Read-Through Fill Capture for One Storage Level

This block sits in the controller of one level of a storage hierarchy. All levels share one broadcast bus. On a miss, the nearest lower level that holds the data sends its whole transfer unit over that bus. It sends one word per beat, and each beat carries the word's address. Every level above the source watches the same broadcast. Each one keeps only the words that fall in its own aligned unit around the requested address. In this way every upper level fills from a single pass instead of copying the unit one level at a time.

A fill starts with a request that names the missed address. The capture window is that address with its low `UNIT_LOG2` bits cleared. The block turns each in-window beat into a write on its local storage port. It also forwards the exact requested word to the consumer in the same cycle that word appears. It reports the new unit as installed only after every word of the window has arrived. This keeps the level's contents a subset of the level below it. When the level is disabled, it ignores the bus and the other levels see no change.

Top module: `rtf_fill_capture`

## Requirements
- R1: After reset, `unit_valid`, `fill_done`, `wr_en` and `fwd_valid` are all 0.
- R2: While a fill is pending, a beat whose address with the low `UNIT_LOG2` bits cleared equals the request's aligned base raises `wr_en` in the same cycle. In that cycle, `wr_idx` equals the beat address's low `UNIT_LOG2` bits and `wr_data` equals the beat data. When the broadcast unit is the same size as this level's unit, every beat is written.
- R3: A beat outside the window is not written and does not count toward completion. This covers the case where a more distant source broadcasts a larger unit.
- R4: `unit_valid` is set, `unit_tag` takes the request address shifted right by `UNIT_LOG2`, and `fill_done` pulses for one cycle. All three happen in the cycle after the last missing word of the window is captured, in any beat order, and never earlier. `unit_tag` changes only together with `fill_done`.
- R5: `fwd_valid` is 1 in the same cycle as a beat whose address equals the requested address exactly. In that cycle, `fwd_data` equals the beat data.
- R6: A request clears `unit_valid` on the next cycle and restarts collection. A request has priority over a beat in the same cycle, so that beat is neither written nor forwarded.
- R7: While `lvl_en` is 0, requests and beats are ignored. There are no writes or forwards, and the collection progress, `unit_valid` and `unit_tag` hold their values.
- R8: A repeated beat for a word already captured is written again but is not counted twice. Completion still needs every distinct offset.
- R9: With no fill pending, beats cause no write and no forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_en | input | 1 | Level present and enabled |
| req_valid | input | 1 | Start a fill for `req_addr` |
| req_addr | input | ADDR_W | Missed word address |
| bus_valid | input | 1 | Broadcast beat present |
| bus_addr | input | ADDR_W | Address of the broadcast word |
| bus_data | input | DATA_W | Broadcast word |
| wr_en | output | 1 | Write one word into local storage |
| wr_idx | output | max(UNIT_LOG2,1) | Word offset inside the unit |
| wr_data | output | DATA_W | Word to store |
| fwd_valid | output | 1 | Requested word is on the bus now |
| fwd_data | output | DATA_W | Requested word |
| unit_valid | output | 1 | Installed unit is complete |
| unit_tag | output | ADDR_W-UNIT_LOG2 | Unit number of the installed unit |
| fill_done | output | 1 | One-cycle pulse when a unit installs |

## Verification
The first pattern is an ascending eight-word broadcast from a more distant source. It shows whether out-of-window beats are rejected and whether the forwarded word lines up with its beat. The second is a four-word broadcast that matches the unit size but arrives out of order. It shows whether completion waits for the last missing offset rather than the highest address. Further patterns use repeated beats, a request arriving in the same cycle as a beat, and disable windows placed before and in the middle of a fill. These tell apart counting by beats and counting by offsets, and they check request priority and the hold of state while disabled. Stray beats after completion confirm that nothing is captured without a pending request.

// File: rtl/rtf_pkg.sv
package rtf_pkg;

    localparam int unsigned RTF_MAX_AW = 32;

    typedef enum logic {
        FILL_IDLE   = 1'b0,
        FILL_ACTIVE = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic in_win;
        logic exact;
    } beat_match_t;

    function automatic logic [RTF_MAX_AW-1:0] align_down(
        input logic [RTF_MAX_AW-1:0] a,
        input int unsigned           lg
    );
        logic [RTF_MAX_AW-1:0] keep;
        keep = ~((RTF_MAX_AW'(1) << lg) - RTF_MAX_AW'(1));
        return a & keep;
    endfunction

endpackage

// File: rtl/rtf_beat_match.sv
module rtf_beat_match
    import rtf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned UNIT_LOG2 = 2,
    localparam int unsigned OFF_W    = (UNIT_LOG2 == 0) ? 1 : UNIT_LOG2
) (
    input  logic [ADDR_W-1:0] want_addr,
    input  logic [ADDR_W-1:0] beat_addr,
    output beat_match_t       match,
    output logic [OFF_W-1:0]  offset
);

    logic [RTF_MAX_AW-1:0] want_base;
    logic [RTF_MAX_AW-1:0] beat_base;

    always_comb begin
        want_base    = align_down(RTF_MAX_AW'(want_addr), UNIT_LOG2);
        beat_base    = align_down(RTF_MAX_AW'(beat_addr), UNIT_LOG2);
        match.in_win = (want_base == beat_base);
        match.exact  = (want_addr == beat_addr);
    end

    generate
        if (UNIT_LOG2 == 0) begin : g_single
            assign offset = 1'b0;
        end else begin : g_multi
            assign offset = beat_addr[OFF_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/rtf_collect_mask.sv
module rtf_collect_mask #(
    parameter int unsigned UNIT_LOG2 = 2,
    localparam int unsigned OFF_W    = (UNIT_LOG2 == 0) ? 1 : UNIT_LOG2,
    localparam int unsigned WORDS    = 1 << UNIT_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             take,
    input  logic [OFF_W-1:0] offset,
    output logic             complete
);

    logic [WORDS-1:0] seen_q;
    logic [WORDS-1:0] hit_vec;

    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_word
            assign hit_vec[i] = take && (offset == OFF_W'(i));
        end
    endgenerate

    assign complete = take && (&(seen_q | hit_vec));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            seen_q <= '0;
        end else if (complete) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_q | hit_vec;
        end
    end

endmodule

// File: rtl/rtf_fill_capture.sv
module rtf_fill_capture
    import rtf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned UNIT_LOG2 = 2,
    localparam int unsigned OFF_W    = (UNIT_LOG2 == 0) ? 1 : UNIT_LOG2,
    localparam int unsigned TAG_W    = ADDR_W - UNIT_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              unit_valid,
    output logic [TAG_W-1:0]  unit_tag,
    output logic              fill_done
);

    fill_state_e       state_q;
    logic [ADDR_W-1:0] want_q;
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic              done_q;

    beat_match_t       bm;
    logic [OFF_W-1:0]  beat_off;
    logic              start_fill;
    logic              listening;
    logic              take_beat;
    logic              fill_complete;

    rtf_beat_match #(
        .ADDR_W    (ADDR_W),
        .UNIT_LOG2 (UNIT_LOG2)
    ) u_match (
        .want_addr (want_q),
        .beat_addr (bus_addr),
        .match     (bm),
        .offset    (beat_off)
    );

    // A new request wins over any beat arriving in the same cycle.
    assign start_fill = lvl_en && req_valid;
    assign listening  = lvl_en && !req_valid && (state_q == FILL_ACTIVE);
    assign take_beat  = listening && bus_valid && bm.in_win;

    rtf_collect_mask #(
        .UNIT_LOG2 (UNIT_LOG2)
    ) u_mask (
        .clk      (clk),
        .rst      (rst),
        .restart  (start_fill),
        .take     (take_beat),
        .offset   (beat_off),
        .complete (fill_complete)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FILL_IDLE;
            want_q  <= '0;
            valid_q <= 1'b0;
            tag_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_fill) begin
                state_q <= FILL_ACTIVE;
                want_q  <= req_addr;
                valid_q <= 1'b0;
            end else if (fill_complete) begin
                state_q <= FILL_IDLE;
                valid_q <= 1'b1;
                tag_q   <= want_q[ADDR_W-1:UNIT_LOG2];
                done_q  <= 1'b1;
            end
        end
    end

    assign wr_en      = take_beat;
    assign wr_idx     = beat_off;
    assign wr_data    = bus_data;
    assign fwd_valid  = listening && bus_valid && bm.exact;
    assign fwd_data   = bus_data;
    assign unit_valid = valid_q;
    assign unit_tag   = tag_q;
    assign fill_done  = done_q;

    // R4: a completion pulse always comes with an installed unit
    assert_done_has_valid_R4: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> unit_valid);

    // R4: the completion pulse lasts exactly one cycle
    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> !fill_done);

    // R4: the installed tag moves only on completion
    assert_tag_moves_on_done_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(unit_tag) |-> fill_done);

    // R6: a request drops the installed unit on the next cycle
    assert_request_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (lvl_en && req_valid) |=> !unit_valid);

    // R7: a disabled level neither writes nor forwards
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !lvl_en |-> (!wr_en && !fwd_valid));

    // R9: storage writes only happen during a pending fill
    assert_write_needs_fill_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (state_q == FILL_ACTIVE));

endmodule

// File: tb/test_rtf_fill_capture.sv
module test_rtf_fill_capture;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int UL = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lvl_en = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic          wr_en;
    logic [UL-1:0] wr_idx;
    logic [DW-1:0] wr_data;
    logic          fwd_valid;
    logic [DW-1:0] fwd_data;
    logic          unit_valid;
    logic [AW-UL-1:0] unit_tag;
    logic          fill_done;

    always #5 clk = ~clk;

    rtf_fill_capture #(.ADDR_W(AW), .DATA_W(DW), .UNIT_LOG2(UL)) i_rtf_fill_capture (
        .clk(clk), .rst(rst), .lvl_en(lvl_en),
        .req_valid(req_valid), .req_addr(req_addr),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .unit_valid(unit_valid), .unit_tag(unit_tag), .fill_done(fill_done)
    );

    int    compared = 0;
    int    mismatched = 0;
    string cur_tag = "R1";
    bit    started = 0;
    bit    finished = 0;

    // behavioural reference state
    bit    m_pend, m_valid, m_done;
    int    m_req, m_tag;
    bit    m_got[4];

    task automatic chk(input string what, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_pend = 0; m_valid = 0; m_done = 0; m_tag = 0; m_req = 0;
            foreach (m_got[k]) m_got[k] = 0;
        end else begin
            m_done = 0;
            if (lvl_en && req_valid) begin
                m_pend = 1; m_req = int'(req_addr); m_valid = 0;
                foreach (m_got[k]) m_got[k] = 0;
            end else if (lvl_en && m_pend && bus_valid && (int'(bus_addr) / 4 == m_req / 4)) begin
                m_got[int'(bus_addr) % 4] = 1;
                if (m_got[0] && m_got[1] && m_got[2] && m_got[3]) begin
                    m_pend = 0; m_valid = 1; m_done = 1; m_tag = m_req / 4;
                    foreach (m_got[k]) m_got[k] = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            bit e_wr, e_fwd;
            e_wr  = lvl_en && m_pend && !req_valid && bus_valid && (int'(bus_addr) / 4 == m_req / 4);
            e_fwd = lvl_en && m_pend && !req_valid && bus_valid && (int'(bus_addr) == m_req);
            chk("wr_en", wr_en, e_wr);
            if (e_wr) begin
                chk("wr_idx", wr_idx, int'(bus_addr) % 4);
                chk("wr_data", wr_data, bus_data);
            end
            chk("fwd_valid", fwd_valid, e_fwd);
            if (e_fwd) chk("fwd_data", fwd_data, bus_data);
            chk("unit_valid", unit_valid, m_valid);
            chk("unit_tag", unit_tag, m_tag);
            chk("fill_done", fill_done, m_done);
        end
    end

    task automatic step(input bit en, input bit rv, input int ra, input bit bv, input int ba);
        @(negedge clk);
        #1;
        lvl_en    = en;
        req_valid = rv;
        req_addr  = AW'(ra);
        bus_valid = bv;
        bus_addr  = AW'(ba);
        bus_data  = {16'hD0A7, 16'(ba)} ^ 32'h0000_5A00;
    endtask

    task automatic req(input int a);
        step(1, 1, a, 0, 0);
    endtask

    task automatic beat(input int a);
        step(1, 0, 0, 1, a);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!finished) begin
            @(posedge clk);
            wd++;
            if (wd > 20000) begin
                mismatched++;
                $display("FAIL watchdog expired in %s", cur_tag);
                finished = 1;
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        idle(2);

        // R2 R3 R5: eight-word ascending broadcast, only upper half in window
        cur_tag = "R3";
        req(16'h0106);
        for (int a = 16'h0100; a < 16'h0104; a++) beat(a);
        cur_tag = "R2";
        for (int a = 16'h0104; a < 16'h0108; a++) beat(a);
        cur_tag = "R5";
        idle(3);

        // R4: unit equals broadcast size, out-of-order beats with gaps
        cur_tag = "R4";
        req(16'h0203);
        beat(16'h0203);
        idle(1);
        beat(16'h0201);
        beat(16'h0200);
        idle(2);
        beat(16'h0202);
        idle(3);

        // R8: repeated beat does not count twice
        cur_tag = "R8";
        req(16'h0311);
        beat(16'h0310);
        beat(16'h0310);
        beat(16'h0311);
        beat(16'h0312);
        idle(2);
        beat(16'h0313);
        idle(2);

        // R6: new request in the same cycle as a beat, then restart
        cur_tag = "R6";
        req(16'h0400);
        beat(16'h0400);
        beat(16'h0401);
        step(1, 1, 16'h0508, 1, 16'h0402);
        beat(16'h0403);
        for (int a = 16'h0508; a < 16'h050C; a++) beat(a);
        idle(2);

        // R7: disabled level ignores request and beats, then pauses mid-fill
        cur_tag = "R7";
        step(0, 1, 16'h0600, 0, 0);
        step(0, 0, 0, 1, 16'h0600);
        step(0, 0, 0, 1, 16'h0601);
        idle(1);
        req(16'h0702);
        beat(16'h0700);
        beat(16'h0701);
        step(0, 0, 0, 1, 16'h0702);
        step(0, 0, 0, 1, 16'h0703);
        idle(1);
        beat(16'h0702);
        beat(16'h0703);
        idle(2);

        // R9: beats with no pending fill
        cur_tag = "R9";
        for (int a = 16'h0700; a < 16'h0704; a++) beat(a);
        beat(16'h0800);
        idle(3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule